// File: doc/BRIEF.md
# Bus-Mapped Watchdog Timer

This block is a watchdog timer peripheral that software reaches through an APB slave port. Software programs a reload value, and a down-counter then steps toward zero once per watchdog tick. The tick is a clock-enable pulse that is already synchronous to the bus clock. When the count runs out, the counter refills itself from the reload value and raises an interrupt. If software still has not acknowledged that interrupt when the count runs out again, the block raises a reset request that stays high until the block itself is reset.

Two control bits act independently. One enables counting and interrupt delivery. The other allows the second-expiry reset. A status register shows the unmasked interrupt state. A second register shows the live count, so software can observe the timer without side effects. Writing the acknowledge register with any value services the watchdog.

Top module: `wdog_apb`

## Requirements
- R1: After reset, the reload register (offset 0x00) and the live count (0x04) both read all ones. The control register (0x08) reads 0. The raw status (0x10) reads 0. irq_o and rst_o are low.
- R2: A write to offset 0x00 stores the reload value and restarts the count from that value in the same clock. Both 0x00 and 0x04 then read the written value.
- R3: While control bit 0 is set, every cycle with tick_en high lowers the count by exactly one, as long as the count is not zero.
- R4: A tick that finds the count at zero refills the count from the reload register and sets the raw interrupt status.
- R5: irq_o equals raw status AND control bit 0. Clearing bit 0 freezes the count. A write that sets bit 0 while it was clear refills the count from the reload register.
- R6: A write of any data value to offset 0x0C clears the raw interrupt status and refills the count from the reload register.
- R7: A tick at count zero raises rst_o when the raw interrupt status is already set and control bit 1 is set. rst_o then stays high until presetn is asserted. With bit 1 clear, rst_o never rises.
- R8: Offset 0x10 bit 0 reads the raw interrupt status whatever the value of control bit 0. Offset 0x08 reads back the two control bits: bit 0 enables counting and the interrupt, bit 1 enables reset.
- R9: pready is always 1 and pslverr is always 0. Reads of offset 0x0C and of any offset not listed above return 0.
- R10: A register write that restarts the count takes priority over a tick in the same clock. The tick is lost, and no expiry is seen in that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and watchdog clock |
| presetn | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Synchronous watchdog tick enable |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never an error |
| irq_o | output | 1 | Masked watchdog interrupt |
| rst_o | output | 1 | Sticky reset request |

## Verification
The embedded properties check on every cycle the single-step behaviour of the counter: decrement by one, freezing when not enabled, refill on expiry, and restart to the selected value. They also check that acknowledge clears the status, that the reset request is sticky, and that the reset request only rises from an expiry with status pending and reset enabled. They show that irq_o is never high while counting is disabled. Only the bench's scenarios can show the end-to-end sequences: the interrupt appearing after reload-plus-one ticks, reset following a second unacknowledged expiry and not a first, the refill when bit 0 is re-enabled, a write winning over a coincident tick, and the register read-back values.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned OFS_RELOAD = 32'h00;
   localparam int unsigned OFS_VALUE  = 32'h04;
   localparam int unsigned OFS_CTRL   = 32'h08;
   localparam int unsigned OFS_ACK    = 32'h0C;
   localparam int unsigned OFS_RAW    = 32'h10;

   typedef struct packed {
      logic rst_en;
      logic run_en;
   } wdog_ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   input  logic [CNT_W-1:0]  count,
   input  logic              irq_raw,
   output logic [DATA_W-1:0] prdata,
   output logic [CNT_W-1:0]  load_q,
   output wdog_ctrl_t        ctrl_q,
   output logic              restart,
   output logic [CNT_W-1:0]  reload_val,
   output logic              ack
);
   localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFS_RELOAD);
   localparam logic [ADDR_W-1:0] A_VALUE  = ADDR_W'(OFS_VALUE);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);
   localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(OFS_RAW);

   if (ADDR_W < 5) begin : g_chk_addr
      $error("wdog_regs: ADDR_W must reach offset 0x10");
   end
   if (CNT_W > DATA_W) begin : g_chk_cnt
      $error("wdog_regs: CNT_W must not exceed DATA_W");
   end
   if (DATA_W < 2) begin : g_chk_data
      $error("wdog_regs: DATA_W too small for control bits");
   end

   logic wr_en, wr_reload, wr_ctrl, wr_ack;
   logic [DATA_W-1:0] count_ext, load_ext;

   assign wr_en     = psel & penable & pwrite;
   assign wr_reload = wr_en & (paddr == A_RELOAD);
   assign wr_ctrl   = wr_en & (paddr == A_CTRL);
   assign wr_ack    = wr_en & (paddr == A_ACK);
   assign ack       = wr_ack;

   assign restart    = wr_reload | wr_ack | (wr_ctrl & pwdata[0] & ~ctrl_q.run_en);
   assign reload_val = wr_reload ? pwdata[CNT_W-1:0] : load_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= RESET_LOAD;
         ctrl_q <= '0;
      end else begin
         if (wr_reload) load_q <= pwdata[CNT_W-1:0];
         if (wr_ctrl)   ctrl_q <= '{rst_en: pwdata[1], run_en: pwdata[0]};
      end
   end

   if (CNT_W == DATA_W) begin : g_full
      assign count_ext = count;
      assign load_ext  = load_q;
   end else begin : g_pad
      assign count_ext = {{(DATA_W-CNT_W){1'b0}}, count};
      assign load_ext  = {{(DATA_W-CNT_W){1'b0}}, load_q};
   end

   always_comb begin
      prdata = '0;
      unique case (paddr)
         A_RELOAD: prdata = load_ext;
         A_VALUE:  prdata = count_ext;
         A_CTRL:   prdata[1:0] = {ctrl_q.rst_en, ctrl_q.run_en};
         A_RAW:    prdata[0] = irq_raw;
         default:  prdata = '0;
      endcase
   end

   // R2: the reload register takes the written value
   a_r2_reload_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reload |=> load_q == $past(pwdata[CNT_W-1:0]));
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CNT_W = 32,
   parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic             restart,
   input  logic [CNT_W-1:0] reload_val,
   input  logic [CNT_W-1:0] load_q,
   output logic [CNT_W-1:0] count,
   output logic             expire
);
   if (CNT_W < 2) begin : g_chk_w
      $error("wdog_counter: CNT_W must be at least 2");
   end

   logic step, at_zero;
   assign step    = run & tick & ~restart;
   assign at_zero = (count == '0);
   assign expire  = step & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= RESET_LOAD;
      else if (restart)  count <= reload_val;
      else if (step)     count <= at_zero ? load_q : count - 1'b1;
   end

   a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      run && tick && !restart && count != '0 |=> count == $past(count) - 1'b1);
   a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !restart && !(run && tick) |=> $stable(count));
   a_r4_refill: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> count == $past(load_q));
   a_r10_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> count == $past(reload_val));
endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic ack,
   input  logic rst_en,
   input  logic run_en,
   output logic irq_raw,
   output logic irq_o,
   output logic rst_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_raw <= 1'b0;
         rst_o   <= 1'b0;
      end else begin
         if (ack)         irq_raw <= 1'b0;
         else if (expire) irq_raw <= 1'b1;
         if (expire && irq_raw && rst_en) rst_o <= 1'b1;
      end
   end

   assign irq_o = irq_raw & run_en;

   a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !irq_raw);
   a_r4_expire_sets: assert property (@(posedge clk) disable iff (!rst_n)
      expire && !ack |=> irq_raw);
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      rst_o |=> rst_o);
   a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_o) |-> $past(expire && irq_raw && rst_en));
endmodule

// File: rtl/wdog_apb.sv
module wdog_apb
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32,
   parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              tick_en,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   output logic              pready,
   output logic              pslverr,
   output logic              irq_o,
   output logic              rst_o
);
   logic [CNT_W-1:0] count, load_q, reload_val;
   wdog_ctrl_t       ctrl_q;
   logic             restart, ack, expire, irq_raw;

   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   wdog_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)
   ) u_regs (
      .clk(pclk), .rst_n(presetn),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata),
      .count(count), .irq_raw(irq_raw),
      .prdata(prdata), .load_q(load_q), .ctrl_q(ctrl_q),
      .restart(restart), .reload_val(reload_val), .ack(ack)
   );

   wdog_counter #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)) u_counter (
      .clk(pclk), .rst_n(presetn),
      .run(ctrl_q.run_en), .tick(tick_en), .restart(restart),
      .reload_val(reload_val), .load_q(load_q),
      .count(count), .expire(expire)
   );

   wdog_alarm u_alarm (
      .clk(pclk), .rst_n(presetn),
      .expire(expire), .ack(ack),
      .rst_en(ctrl_q.rst_en), .run_en(ctrl_q.run_en),
      .irq_raw(irq_raw), .irq_o(irq_o), .rst_o(rst_o)
   );

   a_r5_masked: assert property (@(posedge pclk) disable iff (!presetn)
      irq_o |-> ctrl_q.run_en);
   a_r7_needs_enable: assert property (@(posedge pclk) disable iff (!presetn)
      !ctrl_q.rst_en && !rst_o |=> !rst_o);
endmodule

// File: tb/wdog_apb_bench.sv
`timescale 1ns/1ps
module wdog_apb_bench;
   logic        clk = 1'b0;
   logic        presetn = 1'b0;
   logic        tick_en = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [7:0]  paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic        pready, pslverr, irq_o, rst_o;

   int n_checks = 0;
   int n_fail   = 0;
   int tdiv = 0;
   int tcnt = 0;
   int cycles = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [31:0] m_load, m_count;
   logic        m_ie, m_re, m_irq, m_rst;

   always #10 clk = ~clk;

   wdog_apb u_wdog_apb (
      .pclk(clk), .presetn(presetn), .tick_en(tick_en),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .irq_o(irq_o), .rst_o(rst_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         8'h00:   return m_load;
         8'h04:   return m_count;
         8'h08:   return {30'b0, m_re, m_ie};
         8'h10:   return {31'b0, m_irq};
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!presetn) begin
         m_load = 32'hFFFF_FFFF; m_count = 32'hFFFF_FFFF;
         m_ie = 0; m_re = 0; m_irq = 0; m_rst = 0;
      end else begin
         logic ie_old, re_old, rs;
         ie_old = m_ie; re_old = m_re; rs = 0;
         if (psel && penable && pwrite) begin
            case (paddr)
               8'h00: begin m_load = pwdata; m_count = pwdata; rs = 1; end
               8'h08: begin
                  if (pwdata[0] && !m_ie) begin m_count = m_load; rs = 1; end
                  m_ie = pwdata[0]; m_re = pwdata[1];
               end
               8'h0C: begin m_irq = 0; m_count = m_load; rs = 1; end
               default: ;
            endcase
         end
         if (!rs && ie_old && tick_en) begin
            if (m_count == 0) begin
               m_count = m_load;
               if (m_irq && re_old) m_rst = 1;
               m_irq = 1;
            end else m_count = m_count - 1;
         end
      end
   end

   // tick generator: tdiv==0 means no ticks, otherwise one tick every tdiv cycles
   always @(negedge clk) begin
      if (tdiv == 0) tick_en <= 1'b0;
      else begin
         tcnt++;
         tick_en <= (tcnt % tdiv) == 0;
      end
   end

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      if (presetn && !done) begin
         check("R5 irq_o vs model", {31'b0, irq_o}, {31'b0, m_irq & m_ie});
         check("R7 rst_o vs model", {31'b0, rst_o}, {31'b0, m_rst});
         check("R9 pready/pslverr", {30'b0, pready, pslverr}, 32'h2);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         done = 1'b1;
         n_checks++; n_fail++;
         $display("FAIL watchdog expired act=%0d exp<=100000", cycles);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1;
      @(negedge clk);
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_read(input logic [7:0] a, output logic [31:0] v, output logic [31:0] mv);
      @(negedge clk);
      psel = 1; pwrite = 0; penable = 0; paddr = a;
      @(negedge clk);
      penable = 1;
      v = prdata; mv = m_read(a);
      @(negedge clk);
      psel = 0; penable = 0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v, mv;
      apb_read(a, v, mv);
      check(tag, v, exp);
      check({tag, " (model)"}, v, mv);
   endtask

   initial begin
      logic [31:0] v1, v2, mv;
      wait_cyc(3);
      presetn = 1;
      // R1 reset state
      check("R1 irq_o at reset", {31'b0, irq_o}, 32'h0);
      check("R1 rst_o at reset", {31'b0, rst_o}, 32'h0);
      rd_chk("R1 reload reset", 8'h00, 32'hFFFF_FFFF);
      rd_chk("R1 count reset", 8'h04, 32'hFFFF_FFFF);
      rd_chk("R1 ctrl reset", 8'h08, 32'h0);
      rd_chk("R1 raw reset", 8'h10, 32'h0);
      // R9 unmapped and write-only offsets
      rd_chk("R9 ack reads zero", 8'h0C, 32'h0);
      rd_chk("R9 unmapped 0x14", 8'h14, 32'h0);
      rd_chk("R9 unmapped 0x40", 8'h40, 32'h0);
      // R2 load and restart
      apb_write(8'h00, 32'd5);
      rd_chk("R2 reload readback", 8'h00, 32'd5);
      rd_chk("R2 count restarted", 8'h04, 32'd5);
      // R5 disabled counter frozen under ticks
      tdiv = 1;
      wait_cyc(6);
      rd_chk("R5 frozen while disabled", 8'h04, 32'd5);
      // R3/R4 enable and run to expiry
      apb_write(8'h08, 32'h1);
      wait_cyc(10);
      check("R4 irq after expiry", {31'b0, irq_o}, 32'h1);
      rd_chk("R8 raw status set", 8'h10, 32'h1);
      rd_chk("R8 ctrl readback", 8'h08, 32'h1);
      // R7 negative: reset disabled, many expiries, no reset
      wait_cyc(20);
      check("R7 no reset when bit1 clear", {31'b0, rst_o}, 32'h0);
      // R5 mask and freeze
      apb_write(8'h08, 32'h0);
      check("R5 irq masked", {31'b0, irq_o}, 32'h0);
      rd_chk("R8 raw with enable clear", 8'h10, 32'h1);
      apb_read(8'h04, v1, mv);
      wait_cyc(5);
      apb_read(8'h04, v2, mv);
      check("R5 count frozen", v2, v1);
      // R6 acknowledge clears and reloads, arbitrary data
      tdiv = 0;
      apb_write(8'h00, 32'd7);
      apb_write(8'h08, 32'h0);
      apb_write(8'h0C, 32'hDEAD_BEEF);
      rd_chk("R6 raw cleared", 8'h10, 32'h0);
      rd_chk("R6 count reloaded", 8'h04, 32'd7);
      // R5 re-enable refills
      apb_write(8'h00, 32'd9);
      apb_write(8'h08, 32'h0);
      apb_write(8'h08, 32'h1);
      rd_chk("R5 refill on enable", 8'h04, 32'd9);
      // R3 single tick decrement
      tdiv = 3;
      wait_cyc(7);
      tdiv = 0;
      wait_cyc(2);
      apb_read(8'h04, v1, mv);
      check("R3 decrement per tick", v1, mv);
      // R10 write wins over coincident tick
      tdiv = 1;
      wait_cyc(2);
      apb_write(8'h00, 32'd100);
      rd_chk("R10 write beats tick", 8'h04, 32'd98);
      // R7 second expiry with reset enabled
      apb_write(8'h00, 32'd3);
      apb_write(8'h08, 32'h3);
      apb_write(8'h0C, 32'h0);
      wait_cyc(5);
      check("R7 first expiry no reset", {31'b0, rst_o}, 32'h0);
      wait_cyc(10);
      check("R7 reset after second expiry", {31'b0, rst_o}, 32'h1);
      apb_write(8'h0C, 32'h1);
      apb_write(8'h08, 32'h0);
      wait_cyc(4);
      check("R7 reset sticky", {31'b0, rst_o}, 32'h1);
      tdiv = 0;
      @(negedge clk);
      presetn = 0;
      wait_cyc(2);
      presetn = 1;
      check("R7 reset cleared by presetn", {31'b0, rst_o}, 32'h0);
      rd_chk("R1 reload after reset", 8'h00, 32'hFFFF_FFFF);
      wait_cyc(2);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule